// File: doc/BRIEF.md
# Tiered Write-Protected PWM Configuration Registers

This block stores the configuration fields of a multi-channel PWM timer and guards them against stray software writes. A single-cycle write strobe (address, data, enable) updates the fields, and a combinational read port returns what is stored. The fields are the dead-time code, the per-output idle levels, the break enable, break polarity and automatic output enable bits, the off-state selects for run and idle, the per-channel output polarity bits, the per-channel compare mode and preload bits, and a per-channel direction bit.

A two-bit protection level is held in the control word. It can be written once after reset. Each higher level protects everything the lower levels protect, plus more. Polarity and compare settings are guarded only for channels whose direction bit marks them as outputs. A write that targets a guarded field leaves that field unchanged and raises no error. Unguarded fields in the same word still take the new data. Every protection decision uses the level and the direction bits as they stood before the write.

Top module: `pwmlk_top`

## Requirements
- R1: After reset, every mapped address (0 to 4) reads zero, the protection level is 0 and the level field is writable.
- R2: At level 0, a write updates every field at its address. The map is as follows. Address 0 holds dead time in [7:0], break enable in [8], break polarity in [9], auto output enable in [10], off-state run in [11], off-state idle in [12] and the level in [14:13]. Address 1 holds idle levels, with channel c at [2c+1:2c]. Address 2 holds polarity, with channel c at [2c+1:2c]. Address 3 holds direction, with channel c at [c] and 1 meaning output. Address 4 holds compare, with channel c at [4c+3:4c]: mode in the low 3 bits and preload in the top bit.
- R3: Only the first write to address 0 after reset sets the level. After that write the level is frozen until reset, even if the value written was 0.
- R4: At level 1 or above, writes to the dead-time code, the idle-level bits and the three break bits are ignored. The off-state bits at address 0 are still updated by the same write.
- R5: At level 2 or above, the off-state bits are ignored on write, and so are the polarity bits of each channel whose direction bit is 1.
- R6: At level 3, the compare bits of each channel whose direction bit is 1 are ignored on write. Compare bits of input channels stay writable.
- R7: The direction bits are writable at every level. The protection of a channel follows its direction bit as currently stored.
- R8: The write that sets the level is checked against the level before it (0), so all of its fields are stored.
- R9: Writes to unmapped addresses (5 to 7) change no field, and those addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 3 | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | DATA_W | Stored contents at rdAddr, combinational |

## Verification
Each write is sampled on the rising edge where wrEn is high. The stored field, and therefore rdData, shows the result right after that edge, with no further register in the read path. The bench drives a write at a falling edge and drops the strobe at the next falling edge. It then sets rdAddr and compares rdData a nanosecond later, half a cycle after the write edge. Protection-level changes take effect from that same edge, so the very next write already sees the new level.

// File: rtl/pwmlk_pkg.sv
package pwmlk_pkg;
  localparam int ADDR_W = 3;
  localparam int DT_W   = 8;
  localparam int BRK_W  = 3;
  localparam int OFF_W  = 2;
  localparam int LVL_W  = 2;
  localparam int CMP_PER_CH = 4;

  localparam logic [ADDR_W-1:0] ADR_PROT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IDLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_POL  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 3'd4;

  // bit positions inside the address-0 word
  localparam int BRK_LSB = DT_W;
  localparam int OFF_LSB = BRK_LSB + BRK_W;
  localparam int LVL_LSB = OFF_LSB + OFF_W;

  typedef struct packed {
    logic dt;
    logic brk;
    logic off;
    logic lvl;
    logic idle;
    logic dir;
  } wrStrobe_t;
endpackage

// File: rtl/pwmlk_ctrl.sv
module pwmlk_ctrl
  import pwmlk_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LVL_W-1:0]  lvlReq,
  input  logic [NUM_CH-1:0] dirQ,
  output wrStrobe_t         stb,
  output logic [NUM_CH-1:0] polWe,
  output logic [NUM_CH-1:0] cmpWe,
  output logic [LVL_W-1:0]  lockLvl,
  output logic              lockSet
);
  logic hitProt, hitIdle, hitPol, hitDir, hitCmp;
  logic atLvl1, atLvl2, atLvl3;

  always_comb begin
    hitProt = wrEn && (wrAddr == ADR_PROT);
    hitIdle = wrEn && (wrAddr == ADR_IDLE);
    hitPol  = wrEn && (wrAddr == ADR_POL);
    hitDir  = wrEn && (wrAddr == ADR_DIR);
    hitCmp  = wrEn && (wrAddr == ADR_CMP);
    atLvl1  = |lockLvl;
    atLvl2  = lockLvl[1];
    atLvl3  = &lockLvl;
  end

  always_comb begin
    stb.dt   = hitProt && !atLvl1;
    stb.brk  = hitProt && !atLvl1;
    stb.off  = hitProt && !atLvl2;
    stb.lvl  = hitProt && !lockSet;
    stb.idle = hitIdle && !atLvl1;
    stb.dir  = hitDir;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chGate
    assign polWe[c] = hitPol && !(atLvl2 && dirQ[c]);
    assign cmpWe[c] = hitCmp && !(atLvl3 && dirQ[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockLvl <= '0;
      lockSet <= 1'b0;
    end else begin
      if (stb.lvl) lockLvl <= lvlReq;
      if (hitProt) lockSet <= 1'b1;
    end
  end
endmodule

// File: rtl/pwmlk_regs.sv
module pwmlk_regs
  import pwmlk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wrStrobe_t                stb,
  input  logic [NUM_CH-1:0]        polWe,
  input  logic [NUM_CH-1:0]        cmpWe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [LVL_W-1:0]         lockLvl,
  output logic [DATA_W-1:0]        rdData,
  output logic [DT_W-1:0]          dtCode,
  output logic [OFF_W-1:0]         offBits,
  output logic [2*NUM_CH-1:0]      polBits,
  output logic [NUM_CH-1:0]        dirBits,
  output logic [CMP_PER_CH*NUM_CH-1:0] cmpBits
);
  localparam int PAIR_W = 2 * NUM_CH;
  localparam int CMP_W  = CMP_PER_CH * NUM_CH;

  logic [BRK_W-1:0]  brkBits;
  logic [PAIR_W-1:0] idleBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtCode   <= '0;
      brkBits  <= '0;
      offBits  <= '0;
      idleBits <= '0;
      dirBits  <= '0;
    end else begin
      if (stb.dt)   dtCode   <= wrData[DT_W-1:0];
      if (stb.brk)  brkBits  <= wrData[BRK_LSB +: BRK_W];
      if (stb.off)  offBits  <= wrData[OFF_LSB +: OFF_W];
      if (stb.idle) idleBits <= wrData[PAIR_W-1:0];
      if (stb.dir)  dirBits  <= wrData[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polBits <= '0;
      cmpBits <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (polWe[c]) polBits[2*c +: 2] <= wrData[2*c +: 2];
        if (cmpWe[c]) cmpBits[CMP_PER_CH*c +: CMP_PER_CH] <= wrData[CMP_PER_CH*c +: CMP_PER_CH];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_PROT: begin
        rdData[DT_W-1:0]         = dtCode;
        rdData[BRK_LSB +: BRK_W] = brkBits;
        rdData[OFF_LSB +: OFF_W] = offBits;
        rdData[LVL_LSB +: LVL_W] = lockLvl;
      end
      ADR_IDLE: rdData[PAIR_W-1:0] = idleBits;
      ADR_POL:  rdData[PAIR_W-1:0] = polBits;
      ADR_DIR:  rdData[NUM_CH-1:0] = dirBits;
      ADR_CMP:  rdData[CMP_W-1:0]  = cmpBits;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwmlk_top.sv
module pwmlk_top
  import pwmlk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int CMP_W = CMP_PER_CH * NUM_CH;

  wrStrobe_t              stb;
  logic [NUM_CH-1:0]      polWe, cmpWe, dirBits;
  logic [LVL_W-1:0]       lockLvl;
  logic                   lockSet;
  logic [DT_W-1:0]        dtCode;
  logic [OFF_W-1:0]       offBits;
  logic [2*NUM_CH-1:0]    polBits;
  logic [CMP_W-1:0]       cmpBits;

  pwmlk_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .lvlReq(wrData[LVL_LSB +: LVL_W]), .dirQ(dirBits),
    .stb(stb), .polWe(polWe), .cmpWe(cmpWe),
    .lockLvl(lockLvl), .lockSet(lockSet)
  );

  pwmlk_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .polWe(polWe), .cmpWe(cmpWe),
    .wrData(wrData), .rdAddr(rdAddr), .lockLvl(lockLvl), .rdData(rdData),
    .dtCode(dtCode), .offBits(offBits), .polBits(polBits),
    .dirBits(dirBits), .cmpBits(cmpBits)
  );
endmodule

// File: rtl/pwmlk_chk.sv
module pwmlk_chk
  import pwmlk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [2:0]                    wrAddr,
  input logic [DATA_W-1:0]             wrData,
  input logic [LVL_W-1:0]              lockLvl,
  input logic                          lockSet,
  input logic [DT_W-1:0]               dtCode,
  input logic [OFF_W-1:0]              offBits,
  input logic [2*NUM_CH-1:0]           polBits,
  input logic [NUM_CH-1:0]             dirBits,
  input logic [CMP_PER_CH*NUM_CH-1:0]  cmpBits
);
  assert_lvl_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    lockSet |=> $stable(lockLvl));
  assert_set_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    lockSet |=> lockSet);
  assert_dt_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockLvl != 2'b00) |=> $stable(dtCode));
  assert_off_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    lockLvl[1] |=> $stable(offBits));
  assert_dir_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADR_DIR) |=> (dirBits == $past(wrData[NUM_CH-1:0])));
  assert_first_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!lockSet && wrEn && wrAddr == ADR_PROT) |=> (dtCode == $past(wrData[DT_W-1:0])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chChk
    assert_pol_held_R5: assert property (@(posedge clk) disable iff (!rstN)
      (lockLvl[1] && dirBits[c]) |=> $stable(polBits[2*c +: 2]));
    assert_cmp_held_R6: assert property (@(posedge clk) disable iff (!rstN)
      ((&lockLvl) && dirBits[c]) |=> $stable(cmpBits[CMP_PER_CH*c +: CMP_PER_CH]));
  end
endmodule

bind pwmlk_top pwmlk_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .lockLvl(lockLvl), .lockSet(lockSet), .dtCode(dtCode), .offBits(offBits),
  .polBits(polBits), .dirBits(dirBits), .cmpBits(cmpBits)
);

// File: tb/pwmlk_top_tb.sv
module pwmlk_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwmlk_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectRd(input logic [2:0] a, input logic [15:0] exp, input string req);
    rdAddr = a;
    #1;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic testReset();
    doReset();
    for (int a = 0; a < 5; a++) expectRd(3'(a), 16'h0000, "R1");
    expectRd(3'd5, 16'h0000, "R9");
  endtask

  task automatic testUnlocked();
    doReset();
    doWrite(3'd0, 16'h18AB); expectRd(3'd0, 16'h18AB, "R2");
    doWrite(3'd1, 16'h00A5); expectRd(3'd1, 16'h00A5, "R2");
    doWrite(3'd2, 16'h003C); expectRd(3'd2, 16'h003C, "R2");
    doWrite(3'd3, 16'h0005); expectRd(3'd3, 16'h0005, "R2");
    doWrite(3'd4, 16'hBEEF); expectRd(3'd4, 16'hBEEF, "R2");
    // level stayed 00 after first write and is now frozen
    doWrite(3'd0, 16'h6712); expectRd(3'd0, 16'h0712, "R3");
    doWrite(3'd1, 16'h005A); expectRd(3'd1, 16'h005A, "R3");
  endtask

  task automatic testLevel1();
    doReset();
    doWrite(3'd0, 16'h3F5A); expectRd(3'd0, 16'h3F5A, "R8");
    doWrite(3'd0, 16'h40A5); expectRd(3'd0, 16'h275A, "R4");
    doWrite(3'd1, 16'h00FF); expectRd(3'd1, 16'h0000, "R4");
    doWrite(3'd2, 16'h00FF); expectRd(3'd2, 16'h00FF, "R4");
    doWrite(3'd4, 16'h1234); expectRd(3'd4, 16'h1234, "R4");
  endtask

  task automatic testLevel2();
    doReset();
    doWrite(3'd3, 16'h0003);
    doWrite(3'd0, 16'h5800); expectRd(3'd0, 16'h5800, "R8");
    doWrite(3'd2, 16'h00FF); expectRd(3'd2, 16'h00F0, "R5");
    doWrite(3'd0, 16'h0000); expectRd(3'd0, 16'h5800, "R5");
    doWrite(3'd4, 16'hFFFF); expectRd(3'd4, 16'hFFFF, "R5");
    doWrite(3'd3, 16'h0000); expectRd(3'd3, 16'h0000, "R7");
    doWrite(3'd2, 16'h000F); expectRd(3'd2, 16'h000F, "R7");
  endtask

  task automatic testLevel3();
    doReset();
    doWrite(3'd3, 16'h0009);
    doWrite(3'd0, 16'h6000); expectRd(3'd0, 16'h6000, "R6");
    doWrite(3'd4, 16'hFFFF); expectRd(3'd4, 16'h0FF0, "R6");
    doWrite(3'd2, 16'h00FF); expectRd(3'd2, 16'h003C, "R5");
    doWrite(3'd3, 16'h0000);
    doWrite(3'd4, 16'h1234); expectRd(3'd4, 16'h1234, "R7");
    doWrite(3'd6, 16'hFFFF);
    expectRd(3'd6, 16'h0000, "R9");
    expectRd(3'd0, 16'h6000, "R9");
    expectRd(3'd2, 16'h003C, "R9");
    expectRd(3'd3, 16'h0000, "R9");
    expectRd(3'd4, 16'h1234, "R9");
  endtask

  initial begin
    testReset();
    testUnlocked();
    testLevel1();
    testLevel2();
    testLevel3();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule